// File: doc/BRIEF.md
# Frequency Request Serial Link

This block sits between the processor's control-register bus and an off-chip supply regulator. Software sets the clock speed it wants by writing a 7-bit code, counted in MHz. Each such write starts a short serial frame that carries the code to the regulator over three wires: a frame-enable line, a shift clock derived from the processor clock, and one data line. Bits go out most significant first.

A read of the same register does not return the requested value. It returns the clock frequency the processor is measuring right now. A second register holds a standby speed. A rising edge on the interrupt input sends that speed to the regulator without any software write, and it is sent ahead of any software request that is still waiting. A write that arrives while a frame is being sent is held, and only the newest held value is sent. A busy flag shows when a frame is on the wire.

The regulator-side receiver is part of the same module. It samples the three wires in its own clock domain, rebuilds the 7-bit word, and pulses a strobe only after a full frame.

Top module: `freq_req_link`

## Requirements
- R1: After reset, link_frame, link_sclk, rx_strobe and rd_busy are 0, and rx_word and rd_data are 0.
- R2: A write with wr_sel=0 starts one frame. During the frame link_frame stays high for exactly 2*DIV*W clock cycles, with W link_sclk rising edges. rd_busy is 1 while the frame is on the wire and 0 when no frame is being sent.
- R3: The data bits of a frame appear on link_sdata, most significant bit first, one bit per link_sclk high phase. The bits of the frame equal the requested code.
- R4: The receiver shifts in rx_sdata on each rising edge of rx_sclk while rx_frame is high. On the W-th bit it sets rx_word to the rebuilt word and raises rx_strobe for one cycle. This happens exactly once per frame.
- R5: When rd_en is high, rd_data takes the value of meas_freq on the next clock. The last written code has no effect on it.
- R6: A software write made while a frame is in progress is held and sent right after the current frame ends. If several writes arrive during one frame, only the last of them is sent.
- R7: A rising edge on irq sends the value held in the interrupt-speed register as a frame. If a software request is also waiting, the interrupt frame is sent first and the software request follows.
- R8: If rx_frame falls before W bits have been received, rx_strobe does not pulse and rx_word keeps its old value. The next complete frame is received correctly.
- R9: A write with wr_sel=1 only loads the interrupt-speed register and starts no frame.

Parameters: W (code width, 7) and DIV (clock cycles per link_sclk phase, 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = request register, 1 = interrupt-speed register |
| wr_data | input | W | Frequency code to write, in MHz |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | W | Measured frequency captured by the last read |
| rd_busy | output | 1 | A frame is being sent |
| meas_freq | input | W | Measured clock frequency in MHz |
| irq | input | 1 | Interrupt flag; a rising edge requests the interrupt speed |
| link_frame | output | 1 | Serial frame enable |
| link_sclk | output | 1 | Serial shift clock |
| link_sdata | output | 1 | Serial data, MSB first |
| rx_frame | input | 1 | Receiver frame enable |
| rx_sclk | input | 1 | Receiver shift clock |
| rx_sdata | input | 1 | Receiver serial data |
| rx_word | output | W | Last complete word received |
| rx_strobe | output | 1 | One-cycle pulse when a new word arrives |

## Verification
The receiver checks assume that its three inputs change only between clock edges. They also assume that each rx_sclk phase lasts at least one clock, so every rising edge is seen. The bench meets this in two ways: it loops the transmitter's registered outputs straight back into the receiver, and it drives the hand-made frames at falling clock edges, one clock per phase. The read check assumes meas_freq is held steady around a read. The bench changes it only away from rd_en pulses.

// File: rtl/freq_req_link.sv
module freq_req_link #(
  parameter int W   = 7,
  parameter int DIV = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         rd_busy,
  input  logic [W-1:0] meas_freq,
  input  logic         irq,
  output logic         link_frame,
  output logic         link_sclk,
  output logic         link_sdata,
  input  logic         rx_frame,
  input  logic         rx_sclk,
  input  logic         rx_sdata,
  output logic [W-1:0] rx_word,
  output logic         rx_strobe
);
  localparam int CW = $clog2(2 * DIV);
  localparam int BW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(2 * DIV - 1);
  localparam logic [CW-1:0] CNT_HIGH = CW'(DIV);
  localparam logic [BW-1:0] BIT_LAST = BW'(W - 1);
  localparam logic [BW-1:0] BIT_FULL = BW'(W);

  logic [W-1:0]  irq_val, os_val, sh, rd_q;
  logic          os_pend, irq_pend, irq_q, active;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;

  wire irq_rise = irq & ~irq_q;
  wire os_wr    = wr_en & ~wr_sel;
  wire start    = ~active & (os_pend | irq_pend);
  wire bit_end  = active && (cnt == CNT_LAST);

  assign link_frame = active;
  assign link_sclk  = active && (cnt >= CNT_HIGH);
  assign link_sdata = active & sh[W-1];
  assign rd_busy    = active;
  assign rd_data    = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_val  <= '0;
      os_val   <= '0;
      sh       <= '0;
      rd_q     <= '0;
      os_pend  <= 1'b0;
      irq_pend <= 1'b0;
      irq_q    <= 1'b0;
      active   <= 1'b0;
      cnt      <= '0;
      bitn     <= '0;
    end else begin
      irq_q <= irq;
      if (rd_en) rd_q <= meas_freq;
      if (wr_en && wr_sel) irq_val <= wr_data;
      if (os_wr) begin
        os_val  <= wr_data;
        os_pend <= 1'b1;
      end else if (start && !irq_pend) begin
        os_pend <= 1'b0;
      end
      if (irq_rise) irq_pend <= 1'b1;
      else if (start) irq_pend <= 1'b0;
      if (start) begin
        active <= 1'b1;
        sh     <= irq_pend ? irq_val : os_val;
        cnt    <= '0;
        bitn   <= '0;
      end else if (active) begin
        if (bit_end) begin
          cnt <= '0;
          sh  <= sh << 1;
          if (bitn == BIT_LAST) active <= 1'b0;
          else bitn <= bitn + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  logic          rsclk_q, rstb;
  logic [BW-1:0] rcnt;
  logic [W-1:0]  rsh, rword;

  wire           redge = rx_frame & rx_sclk & ~rsclk_q;
  wire [W-1:0]   rnext = {rsh[W-2:0], rx_sdata};

  assign rx_word   = rword;
  assign rx_strobe = rstb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsclk_q <= 1'b0;
      rstb    <= 1'b0;
      rcnt    <= '0;
      rsh     <= '0;
      rword   <= '0;
    end else begin
      rsclk_q <= rx_sclk;
      rstb    <= 1'b0;
      if (!rx_frame) begin
        rcnt <= '0;
      end else if (redge && rcnt != BIT_FULL) begin
        rsh  <= rnext;
        rcnt <= rcnt + 1'b1;
        if (rcnt == BIT_LAST) begin
          rword <= rnext;
          rstb  <= 1'b1;
        end
      end
    end
  end

  assert_sclk_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !link_frame |-> !link_sclk);
  assert_data_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_sclk |-> $stable(link_sdata));
  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> !rx_strobe);
  assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_word != $past(rx_word)) |-> rx_strobe);
  assert_read_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en) |-> (rd_data == $past(meas_freq)));
endmodule

// File: tb/sim_freq_req_link.sv
module sim_freq_req_link;
  localparam int W = 7;
  localparam int DIV = 2;
  localparam int FLEN = 2 * DIV * W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_sel = 0, rd_en = 0, irq = 0;
  logic [W-1:0] wr_data = '0, meas_freq = '0;
  logic [W-1:0] rd_data, rx_word;
  logic rd_busy, link_frame, link_sclk, link_sdata, rx_strobe;
  logic lb = 1'b1, m_frame = 0, m_sclk = 0, m_sdata = 0;

  wire rx_frame = lb ? link_frame : m_frame;
  wire rx_sclk  = lb ? link_sclk  : m_sclk;
  wire rx_sdata = lb ? link_sdata : m_sdata;

  freq_req_link #(.W(W), .DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_busy(rd_busy), .meas_freq(meas_freq),
    .irq(irq), .link_frame(link_frame), .link_sclk(link_sclk), .link_sdata(link_sdata),
    .rx_frame(rx_frame), .rx_sclk(rx_sclk), .rx_sdata(rx_sdata),
    .rx_word(rx_word), .rx_strobe(rx_strobe));

  always #4 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  int tx_n = 0, rx_n = 0;
  int tx_log[512], tx_len[512], tx_bits[512], rx_log[512];
  logic pf = 0, ps = 0;
  int acc = 0, bits = 0, len = 0;

  always @(negedge clk) begin
    cycles++;
    if (link_frame) begin
      len++;
      if (link_sclk && !ps) begin
        acc = ((acc << 1) | int'(link_sdata)) & ((1 << W) - 1);
        bits++;
      end
    end
    if (!link_frame && pf) begin
      tx_log[tx_n] = acc; tx_len[tx_n] = len; tx_bits[tx_n] = bits;
      tx_n++; acc = 0; bits = 0; len = 0;
    end
    if (rx_strobe) begin
      rx_log[rx_n] = int'(rx_word);
      rx_n++;
    end
    pf = link_frame; ps = link_sclk;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write(input logic sel, input int v);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = W'(v);
    @(negedge clk);
    wr_en = 0; wr_sel = 0;
  endtask

  task automatic wait_tx(input int target);
    while (tx_n < target) @(negedge clk);
    idle(2);
  endtask

  task automatic man_bit(input logic b);
    @(negedge clk); m_sdata = b; m_sclk = 0;
    @(negedge clk); m_sclk = 1;
  endtask

  initial begin
    while (cycles < 150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int base, rb;
    idle(3);
    check("R1 frame", int'(link_frame), 0);
    check("R1 sclk", int'(link_sclk), 0);
    check("R1 busy", int'(rd_busy), 0);
    check("R1 strobe", int'(rx_strobe), 0);
    check("R1 rx_word", int'(rx_word), 0);
    check("R1 rd_data", int'(rd_data), 0);
    rst_n = 1;
    idle(3);

    for (int v = 0; v < (1 << W); v++) begin
      base = tx_n; rb = rx_n;
      write(0, v);
      idle(4);
      check("R2 busy during frame", int'(rd_busy), 1);
      wait_tx(base + 1);
      check("R2 busy after frame", int'(rd_busy), 0);
      check("R2 frame length", tx_len[base], FLEN);
      check("R2 sclk edges", tx_bits[base], W);
      check("R3 msb-first value", tx_log[base], v);
      check("R4 one strobe", rx_n - rb, 1);
      check("R4 rx_word", rx_log[rb], v);
    end

    for (int k = 0; k < 8; k++) begin
      meas_freq = W'(17 * k + 5);
      write(0, 99 - k);
      @(negedge clk); rd_en = 1;
      @(negedge clk); rd_en = 0;
      check("R5 read returns measured", int'(rd_data), 17 * k + 5);
      wait_tx(tx_n + 1);
    end

    base = tx_n;
    write(0, 1);
    idle(3);
    write(0, 2);
    write(0, 3);
    wait_tx(base + 2);
    idle(FLEN + 10);
    check("R6 frame count", tx_n - base, 2);
    check("R6 first frame", tx_log[base], 1);
    check("R6 latest held wins", tx_log[base + 1], 3);

    base = tx_n;
    write(1, 90);
    idle(FLEN + 10);
    check("R9 no frame on irq-reg write", tx_n - base, 0);
    @(negedge clk); irq = 1;
    @(negedge clk); irq = 0;
    wait_tx(base + 1);
    check("R7 irq frame value", tx_log[base], 90);

    base = tx_n;
    write(1, 60);
    idle(FLEN + 4);
    write(0, 17);
    idle(3);
    write(0, 34);
    @(negedge clk); irq = 1;
    idle(2); irq = 0;
    wait_tx(base + 3);
    idle(FLEN + 10);
    check("R7 frame count", tx_n - base, 3);
    check("R7 first os frame", tx_log[base], 17);
    check("R7 irq before pending os", tx_log[base + 1], 60);
    check("R7 os after irq", tx_log[base + 2], 34);

    lb = 0;
    rb = rx_n;
    idle(2);
    @(negedge clk); m_frame = 1;
    for (int i = 0; i < 4; i++) man_bit(1'b1);
    @(negedge clk); m_sclk = 0;
    @(negedge clk); m_frame = 0;
    idle(4);
    check("R8 no strobe on short frame", rx_n - rb, 0);
    check("R8 word unchanged", int'(rx_word), 34);
    @(negedge clk); m_frame = 1;
    for (int i = W - 1; i >= 0; i--) man_bit(1'((7'h55 >> i) & 1));
    @(negedge clk); m_sclk = 0;
    @(negedge clk); m_frame = 0;
    idle(3);
    check("R8 full frame after abort strobe", rx_n - rb, 1);
    check("R8 full frame after abort word", int'(rx_word), 'h55);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule